// File: doc/BRIEF.md
# Fractional Rate Clock Enable Generator

This block derives a slow clock enable from a fast reference clock. Two integer divide ratios are used in turn, each for a programmable number of output periods, so the long-run average rate lies between the two ratios. A 24 MHz reference can, for example, give an average close to 32.768 kHz: use ratio 733 for 8 periods, then ratio 732 for 11 periods, and repeat. The block also has a single-ratio mode and a bypass mode. In bypass the reference rate passes straight through.

The output is a one-cycle pulse `tick_o`, synchronous to the reference clock, once per output period. Downstream logic uses it as a clock enable. Two gates control the block. The input gate lets the reference reach the counters. The output gate lets pulses reach the port. Software changes ratios, run lengths and mode bits only while both gates are closed. The bring-up order is:

1. Close both gates.
2. Load the ratios and run lengths.
3. Select the mode.
4. Open the gates.

Top module: `frac_clk_gen`

## Requirements
- R1: While `rst_n` is low, `tick_o` stays 0, even with both gates open and bypass clear.
- R2: The ratio fields `div1_m1` and `div2_m1` hold the divide ratio minus one. With `dual_en`=0 and `bypass_en`=0, every interval between pulses, and the delay from opening the input gate to the first pulse, is `div1_m1`+1 cycles.
- R3: The run-length fields `run1_m1` and `run2_m1` hold a period count minus one. With `dual_en`=1, the pulse intervals repeat as `run1_m1`+1 intervals of `div1_m1`+1 cycles, then `run2_m1`+1 intervals of `div2_m1`+1 cycles.
- R4: The active ratio changes only when a period completes. No interval has a length other than the two programmed ratios.
- R5: With `bypass_en`=1 and both gates open, `tick_o` is 1 on every cycle, whatever the values of `dual_en` and the ratio fields.
- R6: With `gate_out_en`=0, `tick_o` stays 0 while the input gate is open.
- R7: `enabled_o` is 1 exactly when `gate_in_en` or `gate_out_en` is 1.
- R8: Closing `gate_in_en` for one or more cycles resets the phase and run counters. After it reopens, the first interval is `div1_m1`+1 cycles and the sequence starts again with ratio 1.
- R9: In dual mode, the sum of any `run1_m1`+`run2_m1`+2 consecutive intervals that start at a sequence start equals (`run1_m1`+1)(`div1_m1`+1) + (`run2_m1`+1)(`div2_m1`+1).
- R10: A ratio field of 0 gives a pulse on every cycle while that ratio is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div1_m1 | input | 12 | Ratio 1 minus one |
| div2_m1 | input | 12 | Ratio 2 minus one |
| run1_m1 | input | 12 | Periods at ratio 1, minus one |
| run2_m1 | input | 12 | Periods at ratio 2, minus one |
| dual_en | input | 1 | 1 = alternate between the two ratios |
| bypass_en | input | 1 | 1 = pass the reference rate through |
| gate_in_en | input | 1 | Input gate: lets the reference reach the counters |
| gate_out_en | input | 1 | Output gate: lets pulses reach the port |
| tick_o | output | 1 | One-cycle pulse per output period |
| enabled_o | output | 1 | 1 = either gate open |

## Verification
The bench measures each interval between pulses and compares it with the interval its position in the run sequence calls for.

- **Ratio switch timing.** A design that switched ratio in mid-period would give an interval outside the two programmed lengths. A design whose run counter is off by one would give a sequence shifted against the expected one.
- **Restart after gating.** A design that kept its counters while gated would start the restart case with ratio 2 or a short first interval.
- **Ratio zero.** A design that mishandled ratio zero would miss pulses on back-to-back cycles.
- **Bypass precedence.** With bypass set, a design that let the dividers win over bypass would give intervals longer than one cycle.
- **Full-cycle sum.** The typical 733/732 setting is also checked through the sum over a whole sequence.

// File: rtl/frac_clk_pkg.sv
// Package: shared types for the fractional rate clock enable generator.
// Assumes nothing beyond the standard language.
package frac_clk_pkg;
    // Selects which divide ratio is currently active.
    typedef enum logic {
        SEL_DIV1 = 1'b0,
        SEL_DIV2 = 1'b1
    } div_sel_e;
endpackage

// File: rtl/fcg_phase_div.sv
// Phase divider: counts reference cycles up to the active ratio and raises
// a registered one-cycle pulse as each period completes. The combinational
// wrap flag marks the last cycle of a period so the run sequencer can switch
// ratio exactly at a period boundary.
// Assumes ratio_i is held stable within a period, except at the wrap point.
module fcg_phase_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] ratio_i,
    output logic         wrap_o,
    output logic         tick_o
);
    logic [W-1:0] cnt;
    logic         tick_q;

    // Last cycle of the current period.
    always_comb wrap_o = run_i && (cnt >= ratio_i);

    // Phase count and period pulse; cleared whenever the input gate is closed.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt    <= '0;
            tick_q <= 1'b0;
        end else if (wrap_o) begin
            cnt    <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // The phase count never runs past the active ratio (R4).
    assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt <= ratio_i));

    // A nonzero ratio never yields two pulses in a row (R2).
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q && run_i && ratio_i != '0) |=> !tick_q);
endmodule

// File: rtl/fcg_run_seq.sv
// Run-length sequencer: counts completed periods at the active ratio. When
// the run for the active ratio is exhausted, it swaps to the other ratio.
// In single mode it holds ratio 1.
// Assumes wrap_i comes from the phase divider and marks a period's last cycle.
module fcg_run_seq
    import frac_clk_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         wrap_i,
    input  logic         dual_i,
    input  logic [W-1:0] lim1_i,
    input  logic [W-1:0] lim2_i,
    output div_sel_e     sel_o
);
    logic [W-1:0] run_cnt;
    div_sel_e     sel_q;
    logic [W-1:0] lim_act;

    // Run length of the ratio that is currently active.
    always_comb lim_act = (sel_q == SEL_DIV2) ? lim2_i : lim1_i;

    // Period counting and ratio swap at the end of each run.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || !dual_i) begin
            run_cnt <= '0;
            sel_q   <= SEL_DIV1;
        end else if (wrap_i) begin
            if (run_cnt >= lim_act) begin
                run_cnt <= '0;
                sel_q   <= (sel_q == SEL_DIV1) ? SEL_DIV2 : SEL_DIV1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign sel_o = sel_q;

    // The ratio changes only directly after a completed period, or on restart (R4).
    assert_sel_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> ($past(wrap_i) || !$past(run_i) || !$past(dual_i)));

    // Single mode keeps ratio 1 selected (R2).
    assert_single_div1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_i |=> (sel_q == SEL_DIV1));
endmodule

// File: rtl/fcg_out_gate.sv
// Output stage: chooses between the divided pulse and the bypass path, applies
// the output gate and reports whether either gate is open.
// Assumes bypass_i changes only while both gates are closed, so the selection
// never cuts a pulse.
module fcg_out_gate (
    input  logic rst_n,
    input  logic bypass_i,
    input  logic gate_in_i,
    input  logic gate_out_i,
    input  logic tick_div_i,
    output logic tick_o,
    output logic enabled_o
);
    // Source selection and output gating.
    always_comb begin
        if (bypass_i)
            tick_o = rst_n && gate_in_i && gate_out_i;
        else
            tick_o = gate_out_i && tick_div_i;
    end

    // Enabled status follows either gate.
    always_comb enabled_o = gate_in_i || gate_out_i;
endmodule

// File: rtl/frac_clk_gen.sv
// Top level of the fractional rate clock enable generator. It joins the phase
// divider, the run sequencer and the output stage. The active ratio is chosen
// from the sequencer's selection.
// Assumes configuration changes only while both gates are closed.
module frac_clk_gen
    import frac_clk_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int RUN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div1_m1,
    input  logic [DIV_W-1:0] div2_m1,
    input  logic [RUN_W-1:0] run1_m1,
    input  logic [RUN_W-1:0] run2_m1,
    input  logic             dual_en,
    input  logic             bypass_en,
    input  logic             gate_in_en,
    input  logic             gate_out_en,
    output logic             tick_o,
    output logic             enabled_o
);
    logic             wrap;
    logic             tick_div;
    div_sel_e         sel;
    logic [DIV_W-1:0] ratio;

    // Active divide ratio.
    always_comb ratio = (sel == SEL_DIV2) ? div2_m1 : div1_m1;

    fcg_phase_div #(.W(DIV_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (gate_in_en),
        .ratio_i (ratio),
        .wrap_o  (wrap),
        .tick_o  (tick_div)
    );

    fcg_run_seq #(.W(RUN_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (gate_in_en),
        .wrap_i  (wrap),
        .dual_i  (dual_en),
        .lim1_i  (run1_m1),
        .lim2_i  (run2_m1),
        .sel_o   (sel)
    );

    fcg_out_gate u_out (
        .rst_n      (rst_n),
        .bypass_i   (bypass_en),
        .gate_in_i  (gate_in_en),
        .gate_out_i (gate_out_en),
        .tick_div_i (tick_div),
        .tick_o     (tick_o),
        .enabled_o  (enabled_o)
    );

    // A closed input gate restarts the sequence on ratio 1 (R8).
    assert_restart_div1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_in_en |=> (sel == SEL_DIV1));

    // No pulse reaches the port one cycle after the input gate was closed,
    // outside bypass (R8).
    assert_gated_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_in_en && !bypass_en) |=> (!tick_o || bypass_en));

    // The run sequencer leaves ratio 1 only in dual mode (R3).
    assert_div2_needs_dual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DIV2) |-> $past(dual_en));
endmodule

// File: tb/frac_clk_gen_tb.sv
module frac_clk_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div1_m1 = '0, div2_m1 = '0, run1_m1 = '0, run2_m1 = '0;
    logic        dual_en = 1'b0, bypass_en = 1'b0;
    logic        gate_in_en = 1'b0, gate_out_en = 1'b0;
    logic        tick_o, enabled_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    frac_clk_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .div1_m1(div1_m1), .div2_m1(div2_m1),
        .run1_m1(run1_m1), .run2_m1(run2_m1),
        .dual_en(dual_en), .bypass_en(bypass_en),
        .gate_in_en(gate_in_en), .gate_out_en(gate_out_en),
        .tick_o(tick_o), .enabled_o(enabled_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected length of period k from the requirements.
    function automatic int exp_len(int n1, int n2, int m1, int m2, bit dual, int k);
        int l;
        if (!dual) return n1 + 1;
        l = m1 + m2 + 2;
        return ((k % l) < (m1 + 1)) ? n1 + 1 : n2 + 1;
    endfunction

    task automatic cfg(int n1, int n2, int m1, int m2, bit dual, bit byp);
        @(negedge clk);
        gate_in_en = 0; gate_out_en = 0;
        repeat (2) @(negedge clk);
        div1_m1 = 12'(n1); div2_m1 = 12'(n2);
        run1_m1 = 12'(m1); run2_m1 = 12'(m2);
        dual_en = dual; bypass_en = byp;
        @(negedge clk);
        gate_in_en = 1; gate_out_en = 1;
    endtask

    // Measures nper intervals starting now (just after a gate opening or a tick).
    task automatic measure(int n1, int n2, int m1, int m2, bit dual, int nper,
                           string req, bit sum_chk);
        int c = 0, k = 0, sum = 0, guard = 0;
        while (k < nper && guard < 60000) begin
            @(negedge clk);
            c++; guard++;
            if (tick_o) begin
                chk(req, c, exp_len(n1, n2, m1, m2, dual, k));
                sum += c; k++; c = 0;
                if (sum_chk && dual && k == m1 + m2 + 2)
                    chk("R9", sum, (m1 + 1) * (n1 + 1) + (m2 + 1) * (n2 + 1));
            end
        end
        chk({req, " count"}, k, nper);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n1, n2, m1, m2, ticks;
        void'($urandom(32'd4711));
        // R1: reset state with gates open
        gate_in_en = 1; gate_out_en = 1; div1_m1 = 0;
        repeat (3) @(negedge clk);
        chk("R1 tick", int'(tick_o), 0);
        @(negedge clk);
        chk("R1 tick", int'(tick_o), 0);
        gate_in_en = 0; gate_out_en = 0;
        @(negedge clk);
        chk("R7 closed", int'(enabled_o), 0);
        rst_n = 1;

        // R2: single mode, directed
        cfg(4, 9, 1, 1, 0, 0);
        measure(4, 9, 1, 1, 0, 6, "R2", 0);
        // R10: ratio zero
        cfg(0, 0, 0, 0, 0, 0);
        measure(0, 0, 0, 0, 0, 5, "R10", 0);
        // R3/R4: dual directed with ratio 2 of zero
        cfg(3, 0, 1, 2, 1, 0);
        measure(3, 0, 1, 2, 1, 14, "R3", 1);
        // R3/R9: random dual configurations
        for (int t = 0; t < 8; t++) begin
            n1 = $urandom_range(0, 20); n2 = $urandom_range(0, 20);
            m1 = $urandom_range(0, 5);  m2 = $urandom_range(0, 5);
            cfg(n1, n2, m1, m2, 1, 0);
            measure(n1, n2, m1, m2, 1, 2 * (m1 + m2 + 2), "R3", 1);
        end
        // R2: random single
        for (int t = 0; t < 3; t++) begin
            n1 = $urandom_range(1, 30);
            cfg(n1, 5, 2, 2, 0, 0);
            measure(n1, 5, 2, 2, 0, 4, "R2", 0);
        end
        // R9: typical setting
        cfg(732, 731, 7, 10, 1, 0);
        measure(732, 731, 7, 10, 1, 19, "R9", 1);
        // R5: bypass overrides dual
        cfg(9, 7, 2, 2, 1, 1);
        measure(0, 0, 0, 0, 0, 10, "R5", 0);
        // R6/R7: output gate closed
        cfg(2, 2, 0, 0, 0, 0);
        gate_out_en = 0;
        ticks = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick_o) ticks++;
        end
        chk("R6 ticks", ticks, 0);
        chk("R7 in only", int'(enabled_o), 1);
        gate_in_en = 0; gate_out_en = 1;
        @(negedge clk);
        chk("R7 out only", int'(enabled_o), 1);
        gate_out_en = 0;
        @(negedge clk);
        chk("R7 none", int'(enabled_o), 0);
        // R8: restart in the middle of the ratio 2 run
        cfg(5, 2, 0, 3, 1, 0);
        measure(5, 2, 0, 3, 1, 3, "R8 pre", 0);
        gate_in_en = 0;
        repeat (2) @(negedge clk);
        gate_in_en = 1;
        measure(5, 2, 0, 3, 1, 6, "R8", 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule